// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen 32-bit general registers of a processor core, together with the per-mode copies that a mode change must bring into view. Each processor mode maps to one of six banks. When the core asks for a mode whose bank differs from the current one, the live stack pointer (register 13), the link register (register 14) and the saved-status word are stored into the slots of the bank being left. At the same edge they are loaded from the slots of the bank being entered.

Registers 8 to 12 have only two copies. One belongs to the fast-interrupt bank and the other is shared by every other bank. They are exchanged only when the fast-interrupt bank is entered or left. The current mode is held inside the block. Two combinational read ports return live register values. One write port updates a live register, and a separate strobe updates the live saved-status word. Instruction decoding and flag logic belong elsewhere.

Top module: `mode_bank_regfile`

## Requirements
- R1: While reset is low, all live registers, all banked slots and all banked status words are cleared, the live status reads 0 and the mode reads 0x1F (system).
- R2: A mode-change strobe whose requested mode equals the current mode exchanges nothing. A register write in that same cycle still lands in the live register.
- R3: User mode (0x10) and system mode (0x1F) share one bank. Changing between them updates the mode output and moves no register or status word.
- R4: On a change to a different bank, registers 13 and 14 are saved into the old bank and loaded from the new bank.
- R5: On a change to a different bank, the live saved-status word is saved into the old bank and loaded from the new bank.
- R6: Registers 8 to 12 are exchanged only when the old or new mode is fast-interrupt (0x11). They use two copies: the fast-interrupt copy and one copy shared by every other bank.
- R7: A mode change or write takes effect at one clock edge. Both read ports show the resulting value in the following cycle.
- R8: A register write in the same cycle as a bank change is applied before the exchange, so the written value is the one saved into the old bank.
- R9: A requested mode outside the set {0x10 user, 0x11 fast-interrupt, 0x12 interrupt, 0x13 supervisor, 0x17 abort, 0x1B undefined, 0x1F system} is ignored: mode and registers stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_chg | input | 1 | Mode-change strobe |
| mode_req | input | 5 | Requested mode encoding |
| wr_en | input | 1 | Live register write enable |
| wr_idx | input | 4 | Register written |
| wr_data | input | 32 | Write data |
| sts_wr_en | input | 1 | Live saved-status write enable |
| sts_wr_data | input | 32 | Saved-status write data |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| cur_mode | output | 5 | Current mode |
| sts_out | output | 32 | Live saved-status word |

## Verification
A wrong bank index or a missed exchange does not show at once. A wrong value that went into a bank slot appears only when that bank is entered again, which may be several mode changes later. The bench therefore leaves and re-enters banks and reads back registers 8, 9, 13 and 14 and the status word one cycle after each change. It also goes through the fast-interrupt bank and back, so that a confused shared copy of registers 8 to 12 shows up at the read ports.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
    parameter int XLEN    = 32;
    parameter int NREG    = 16;
    parameter int NBANK   = 6;
    parameter int NSLOT   = 7;
    parameter int MODE_W  = 5;
    localparam int IDX_W  = $clog2(NREG);
    localparam int BANK_W = $clog2(NBANK);

    localparam int REG_SP  = 13;
    localparam int REG_LR  = 14;
    localparam int REG_HI0 = 8;
    localparam int NHI     = NSLOT - 2;
    localparam int SLOT_SP  = 0;
    localparam int SLOT_LR  = 1;
    localparam int SLOT_HI0 = 2;

    localparam logic [MODE_W-1:0] MD_USR = 5'h10;
    localparam logic [MODE_W-1:0] MD_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] MD_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] MD_SVC = 5'h13;
    localparam logic [MODE_W-1:0] MD_ABT = 5'h17;
    localparam logic [MODE_W-1:0] MD_UND = 5'h1B;
    localparam logic [MODE_W-1:0] MD_SYS = 5'h1F;

    localparam logic [BANK_W-1:0] BK_COMMON = 3'd0;
    localparam logic [BANK_W-1:0] BK_FIQ    = 3'd1;
    localparam logic [BANK_W-1:0] BK_IRQ    = 3'd2;
    localparam logic [BANK_W-1:0] BK_SVC    = 3'd3;
    localparam logic [BANK_W-1:0] BK_ABT    = 3'd4;
    localparam logic [BANK_W-1:0] BK_UND    = 3'd5;

    typedef struct packed {
        logic [MODE_W-1:0]                       mode;
        logic [XLEN-1:0]                         sts;
        logic [NBANK-1:0][XLEN-1:0]              sts_bank;
        logic [NBANK-1:0][NSLOT-1:0][XLEN-1:0]   bank;
        logic [NREG-1:0][XLEN-1:0]               gpr;
    } rf_state_t;
endpackage

// File: rtl/mbr_bank_sel.sv
module mbr_bank_sel
    import mbr_pkg::*;
(
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [MODE_W-1:0] req_mode,
    output logic              req_valid,
    output logic [BANK_W-1:0] old_bank,
    output logic [BANK_W-1:0] new_bank,
    output logic              bank_change,
    output logic              hi_swap
);
    logic old_valid;

    // Map a mode encoding to its bank; valid is low for unknown encodings.
    function automatic logic [BANK_W:0] map_mode(input logic [MODE_W-1:0] m);
        case (m)
            MD_USR, MD_SYS: map_mode = {1'b1, BK_COMMON};
            MD_FIQ:         map_mode = {1'b1, BK_FIQ};
            MD_IRQ:         map_mode = {1'b1, BK_IRQ};
            MD_SVC:         map_mode = {1'b1, BK_SVC};
            MD_ABT:         map_mode = {1'b1, BK_ABT};
            MD_UND:         map_mode = {1'b1, BK_UND};
            default:        map_mode = {1'b0, BK_COMMON};
        endcase
    endfunction

    always_comb begin
        {old_valid, old_bank} = map_mode(cur_mode);
        {req_valid, new_bank} = map_mode(req_mode);
        bank_change = req_valid && old_valid && (old_bank != new_bank);
        hi_swap     = bank_change && ((old_bank == BK_FIQ) || (new_bank == BK_FIQ));
    end
endmodule

// File: rtl/mbr_read_mux.sv
module mbr_read_mux
    import mbr_pkg::*;
(
    input  logic [NREG-1:0][XLEN-1:0] gpr,
    input  logic [IDX_W-1:0]          idx,
    output logic [XLEN-1:0]           data
);
    assign data = gpr[idx];
endmodule

// File: rtl/mode_bank_regfile.sv
module mode_bank_regfile
    import mbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_chg,
    input  logic [4:0]        mode_req,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [31:0]       wr_data,
    input  logic              sts_wr_en,
    input  logic [31:0]       sts_wr_data,
    input  logic [3:0]        rd_a_idx,
    output logic [31:0]       rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [31:0]       rd_b_data,
    output logic [4:0]        cur_mode,
    output logic [31:0]       sts_out
);
    localparam int NRD = 2;

    rf_state_t st_q, st_d;

    logic              req_valid;
    logic [BANK_W-1:0] old_bank, new_bank, hi_old, hi_new;
    logic              bank_change, hi_swap;

    logic [NRD-1:0][IDX_W-1:0] rd_idx;
    logic [NRD-1:0][XLEN-1:0]  rd_data;

    mbr_bank_sel i_sel (
        .cur_mode   (st_q.mode),
        .req_mode   (mode_req),
        .req_valid  (req_valid),
        .old_bank   (old_bank),
        .new_bank   (new_bank),
        .bank_change(bank_change),
        .hi_swap    (hi_swap)
    );

    assign rd_idx[0] = rd_a_idx;
    assign rd_idx[1] = rd_b_idx;

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        mbr_read_mux i_mux (
            .gpr (st_q.gpr),
            .idx (rd_idx[p]),
            .data(rd_data[p])
        );
    end

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
    assign cur_mode  = st_q.mode;
    assign sts_out   = st_q.sts;

    assign hi_old = (old_bank == BK_FIQ) ? BK_FIQ : BK_COMMON;
    assign hi_new = (new_bank == BK_FIQ) ? BK_FIQ : BK_COMMON;

    always_comb begin
        st_d = st_q;
        // Writes land in the live copy first, so an exchange saves them.
        if (wr_en)     st_d.gpr[wr_idx] = wr_data;
        if (sts_wr_en) st_d.sts         = sts_wr_data;
        if (mode_chg && req_valid && (mode_req != st_q.mode)) begin
            st_d.mode = mode_req;
            if (bank_change) begin
                if (hi_swap) begin
                    for (int i = 0; i < NHI; i++) begin
                        st_d.bank[hi_old][SLOT_HI0+i] = st_d.gpr[REG_HI0+i];
                        st_d.gpr[REG_HI0+i]           = st_q.bank[hi_new][SLOT_HI0+i];
                    end
                end
                st_d.bank[old_bank][SLOT_SP] = st_d.gpr[REG_SP];
                st_d.bank[old_bank][SLOT_LR] = st_d.gpr[REG_LR];
                st_d.gpr[REG_SP]             = st_q.bank[new_bank][SLOT_SP];
                st_d.gpr[REG_LR]             = st_q.bank[new_bank][SLOT_LR];
                st_d.sts_bank[old_bank]      = st_d.sts;
                st_d.sts                     = st_q.sts_bank[new_bank];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MD_SYS;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mbr_checker.sv
module mbr_checker
    import mbr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mode_chg,
    input logic [4:0]        mode_req,
    input logic              wr_en,
    input logic [3:0]        wr_idx,
    input logic              sts_wr_en,
    input logic [4:0]        cur_mode,
    input logic [31:0]       sts_out,
    input rf_state_t         st_q,
    input logic              req_valid,
    input logic [BANK_W-1:0] new_bank,
    input logic              bank_change,
    input logic              hi_swap
);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (cur_mode == MD_SYS && sts_out == '0));

    a_r2_same_mode_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && mode_req == cur_mode && !sts_wr_en)
        |=> ($stable(sts_out) && $stable(cur_mode)));

    a_r3_shared_bank_status: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && !bank_change && !sts_wr_en) |=> $stable(sts_out));

    a_r4_sp_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && bank_change)
        |=> (st_q.gpr[REG_SP] == $past(st_q.bank[new_bank][SLOT_SP])));

    a_r5_status_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && bank_change) |=> (sts_out == $past(st_q.sts_bank[new_bank])));

    a_r6_hi_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && !hi_swap && !(wr_en && wr_idx == 4'd8))
        |=> $stable(st_q.gpr[REG_HI0]));

    a_r9_invalid_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && !req_valid) |=> $stable(cur_mode));
endmodule

bind mode_bank_regfile mbr_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_chg   (mode_chg),
    .mode_req   (mode_req),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .sts_wr_en  (sts_wr_en),
    .cur_mode   (cur_mode),
    .sts_out    (sts_out),
    .st_q       (st_q),
    .req_valid  (req_valid),
    .new_bank   (new_bank),
    .bank_change(bank_change),
    .hi_swap    (hi_swap)
);

// File: tb/test_mode_bank_regfile.sv
module test_mode_bank_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam int K_RA = 0, K_RB = 1, K_STS = 2, K_MODE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_chg = 1'b0;
    logic [4:0]  mode_req = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        sts_wr_en = 1'b0;
    logic [31:0] sts_wr_data = '0;
    logic [3:0]  rd_a_idx = '0;
    logic [31:0] rd_a_data;
    logic [3:0]  rd_b_idx = '0;
    logic [31:0] rd_b_data;
    logic [4:0]  cur_mode;
    logic [31:0] sts_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        int          kind;
        int          idx;
        logic [31:0] val;
        string       tag;
    } item_t;
    item_t sb[$];

    mode_bank_regfile i_mode_bank_regfile (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic expect_item(input int kind, input int idx, input logic [31:0] val,
                               input string tag);
        item_t it;
        it.kind = kind; it.idx = idx; it.val = val; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic drain();
        wait (sb.size() == 0);
    endtask

    task automatic op(input bit chg, input logic [4:0] m, input bit we, input int idx,
                      input logic [31:0] d, input bit se, input logic [31:0] sd);
        @(negedge clk);
        mode_chg = chg; mode_req = m; wr_en = we; wr_idx = idx[3:0]; wr_data = d;
        sts_wr_en = se; sts_wr_data = sd;
        @(negedge clk);
        mode_chg = 1'b0; wr_en = 1'b0; sts_wr_en = 1'b0;
    endtask

    task automatic sw(input logic [4:0] m);
        op(1'b1, m, 1'b0, 0, '0, 1'b0, '0);
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        op(1'b0, 5'h00, 1'b1, idx, d, 1'b0, '0);
    endtask

    // Monitor: pops expected items and compares against the ports.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    K_RA:   begin rd_a_idx = it.idx[3:0]; #1; act = rd_a_data; end
                    K_RB:   begin rd_b_idx = it.idx[3:0]; #1; act = rd_b_data; end
                    K_STS:  act = sts_out;
                    default: act = {27'd0, cur_mode};
                endcase
                checks++;
                if (act !== it.val) begin
                    failures++;
                    $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                             it.tag, it.kind, it.idx, act, it.val);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state
        expect_item(K_MODE, 0, 32'h1F, "R1 mode");
        expect_item(K_STS, 0, 32'h0, "R1 status");
        expect_item(K_RA, 13, 32'h0, "R1 r13");
        expect_item(K_RA, 8, 32'h0, "R1 r8");
        drain();
        @(negedge clk); rst_n = 1'b1;

        wr(13, 32'hA1A1_0013); wr(14, 32'hA1A1_0014); wr(8, 32'hA1A1_0008);
        expect_item(K_RA, 13, 32'hA1A1_0013, "R7 read after write");
        expect_item(K_RB, 14, 32'hA1A1_0014, "R7 port B");
        drain();

        // R3: user shares the system bank
        sw(5'h10);
        expect_item(K_MODE, 0, 32'h10, "R3 mode");
        expect_item(K_RA, 13, 32'hA1A1_0013, "R3 r13 kept");
        expect_item(K_RA, 14, 32'hA1A1_0014, "R3 r14 kept");
        drain();
        op(1'b0, 5'h00, 1'b0, 0, '0, 1'b1, 32'h0000_0055);

        // R4/R5/R6: to supervisor
        sw(5'h13);
        expect_item(K_MODE, 0, 32'h13, "R4 mode");
        expect_item(K_RA, 13, 32'h0, "R4 r13 fresh");
        expect_item(K_RB, 14, 32'h0, "R4 r14 fresh");
        expect_item(K_STS, 0, 32'h0, "R5 status fresh");
        expect_item(K_RA, 8, 32'hA1A1_0008, "R6 r8 not swapped");
        drain();
        wr(13, 32'hB1B1_0013);
        op(1'b0, 5'h00, 1'b0, 0, '0, 1'b1, 32'hB2B2_0000);

        sw(5'h12);
        expect_item(K_RA, 13, 32'h0, "R4 irq r13");
        expect_item(K_STS, 0, 32'h0, "R5 irq status");
        drain();
        sw(5'h13);
        expect_item(K_RA, 13, 32'hB1B1_0013, "R4 svc r13 restored");
        expect_item(K_STS, 0, 32'hB2B2_0000, "R5 svc status restored");
        drain();

        // R8: write during change into fast-interrupt
        op(1'b1, 5'h11, 1'b1, 9, 32'hC9C9_0009, 1'b0, '0);
        expect_item(K_MODE, 0, 32'h11, "R6 fiq mode");
        expect_item(K_RA, 8, 32'h0, "R6 fiq r8");
        expect_item(K_RA, 9, 32'h0, "R8 fiq r9");
        expect_item(K_RB, 13, 32'h0, "R4 fiq r13");
        drain();
        wr(8, 32'hF8F8_0008);

        sw(5'h1F);
        expect_item(K_RA, 8, 32'hA1A1_0008, "R6 shared r8");
        expect_item(K_RA, 9, 32'hC9C9_0009, "R8 write saved");
        expect_item(K_RA, 13, 32'hA1A1_0013, "R4 sys r13");
        expect_item(K_STS, 0, 32'h0000_0055, "R5 sys status");
        drain();

        sw(5'h11);
        expect_item(K_RA, 8, 32'hF8F8_0008, "R6 fiq copy");
        drain();

        // R2: same mode with write
        op(1'b1, 5'h11, 1'b1, 8, 32'hF9F9_0008, 1'b0, '0);
        expect_item(K_MODE, 0, 32'h11, "R2 mode");
        expect_item(K_RA, 8, 32'hF9F9_0008, "R2 write kept");
        expect_item(K_RA, 9, 32'h0, "R2 r9 kept");
        drain();

        // R9: invalid encoding
        sw(5'h05);
        expect_item(K_MODE, 0, 32'h11, "R9 mode");
        expect_item(K_RA, 8, 32'hF9F9_0008, "R9 r8");
        drain();

        sw(5'h1B);
        expect_item(K_MODE, 0, 32'h1B, "R6 und mode");
        expect_item(K_RA, 8, 32'hA1A1_0008, "R6 und r8 shared");
        expect_item(K_RB, 9, 32'hC9C9_0009, "R6 und r9 shared");
        expect_item(K_RA, 13, 32'h0, "R4 und r13");
        drain();

        sw(5'h17);
        expect_item(K_MODE, 0, 32'h17, "R4 abt mode");
        expect_item(K_RA, 14, 32'h0, "R4 abt r14");
        drain();
        sw(5'h13);
        expect_item(K_RA, 13, 32'hB1B1_0013, "R4 svc again");
        expect_item(K_STS, 0, 32'hB2B2_0000, "R5 svc again");
        drain();

        repeat (2) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule